// File: doc/BRIEF.md
# Small Interrupt Controller with Non-Maskable Line

This block gathers up to 32 interrupt lines and drives one request, `irq_o`, to a small management processor. Software reaches it through a simple register bus. Each line has three registers that act on it: a pending latch, an enable bit and a mask bit. A response register holds the lines that are already being serviced. There is no priority scheme. The vector register gives a base address plus four times the index of the lowest qualifying line, so firmware can branch straight to a handler table.

Line 0 is the non-maskable line. Its trigger type is set by software: low level, falling edge, high level or rising edge. Once latched and enabled, line 0 also drives a separate active-high output, `nmi_o`, which goes to the main interrupt distributor. Mask and response do not act on `nmi_o`.

The bus port is a two-state machine. `BUS_IDLE` accepts a request, and that acceptance commits any write and captures the read data. The request moves the machine to `BUS_ACK`, where `bus_ack` is high for one cycle. `BUS_ACK` always returns to `BUS_IDLE`, and a request seen in `BUS_ACK` is not taken.

Top module: `sirq_ctrl`

## Requirements
- R1: A request seen in `BUS_IDLE` produces `bus_ack` high for exactly the following cycle, with read data valid on `bus_rdata` in that cycle. Reads of offsets outside the map return 0, and writes there change no register.
- R2: After reset, the enable, mask, response, pending, base and NMI-mode registers are all 0. The vector register reads 0, and `irq_o` and `nmi_o` are low, provided line 0 is held high.
- R3: For a line configured as level type (lines 1..N-1 whose `EDGE_MASK` bit is 0), the pending bit follows the active-high input. It changes three clock edges after the input does. Writing 1 to its pending bit has no effect.
- R4: For an edge-type line (lines with `EDGE_MASK` bit set; the default is lines 4..7), a rising edge sets the pending bit. The bit stays set after the input falls, until 1 is written to that bit of the pending register at offset 0x10. Other latched bits are not cleared by that write.
- R5: The NMI-mode register at offset 0x0C, bits [1:0], selects the trigger of line 0. 0 is low level, 1 is falling edge, 2 is high level and 3 is rising edge. An edge-latched bit 0 is cleared by a write of 1.
- R6: `nmi_o` is high exactly when pending bit 0 and enable bit 0 are both set, whatever the mask and response registers hold.
- R7: Enable bits 1..N-1 change `irq_o` but never `nmi_o`.
- R8: `irq_o` is the OR over all lines of pending AND enable AND NOT mask AND NOT response.
- R9: The vector register at offset 0x00 reads base + 4·i, where i is the lowest line that is pending, enabled, unmasked and not in service. It reads the base alone when no line qualifies.
- R10: The registers are read and write at these offsets: base at 0x04 (full word), enable at 0x40, mask at 0x50 and response at 0x60. The enable, mask and response registers are N bits wide and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IRQ | Asynchronous interrupt lines, line 0 is the non-maskable one |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | One-cycle access completion |
| bus_rdata | output | DATA_W | Read data, valid while `bus_ack` is high |
| irq_o | output | 1 | Global request to the management processor |
| nmi_o | output | 1 | Level-high non-maskable request to the distributor |

## Verification
The hardest state to reach is a bit-0 latch that must persist. The NMI line has to be switched to an edge mode while its input holds still, so that no false edge appears. The opposite edge must then arrive, and the latch must survive the input's return. The bench walks the four modes in an order where each mode change happens with the input idle. It clears bit 0 before every new edge test. The vector and request are swept over every combination of four level lines, four mask bits and four response bits, which covers every lowest-index case.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam logic [7:0] OFF_VEC  = 8'h00;
    localparam logic [7:0] OFF_BASE = 8'h04;
    localparam logic [7:0] OFF_NMI  = 8'h0C;
    localparam logic [7:0] OFF_PEND = 8'h10;
    localparam logic [7:0] OFF_EN   = 8'h40;
    localparam logic [7:0] OFF_MASK = 8'h50;
    localparam logic [7:0] OFF_RESP = 8'h60;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    // bit 0: edge type, bit 1: active high / rising
    typedef enum logic [1:0] {
        NMI_LOW  = 2'd0,
        NMI_FALL = 2'd1,
        NMI_HIGH = 2'd2,
        NMI_RISE = 2'd3
    } nmi_mode_e;

endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic [N_IRQ-1:0] raw_i,
    output logic [N_IRQ-1:0] cur_o,
    output logic [N_IRQ-1:0] prev_o
);

    for (genvar g = 0; g < N_IRQ; g++) begin : g_stage
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk) begin
            s1_q <= raw_i[g];
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
        assign cur_o[g]  = s2_q;
        assign prev_o[g] = s3_q;
    end

endmodule

// File: rtl/sirq_pending.sv
module sirq_pending
    import sirq_pkg::*;
#(
    parameter int               N_IRQ     = 8,
    parameter logic [N_IRQ-1:0] EDGE_MASK = N_IRQ'(8'hF0)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] cur_i,
    input  logic [N_IRQ-1:0] prev_i,
    input  nmi_mode_e        mode_i,
    input  logic [N_IRQ-1:0] clr_i,
    output logic [N_IRQ-1:0] pend_o
);

    localparam logic [N_IRQ-1:0] BIT0       = N_IRQ'(1);
    localparam logic [N_IRQ-1:0] EDGE_FIXED = EDGE_MASK & ~BIT0;

    logic [N_IRQ-1:0] pend_q;
    logic [N_IRQ-1:0] nxt;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        if (g == 0) begin : g_nmi
            logic rise, fall;
            assign rise   = cur_i[0] & ~prev_i[0];
            assign fall   = ~cur_i[0] & prev_i[0];
            assign nxt[0] = mode_i[0]
                          ? ((pend_q[0] & ~clr_i[0]) | (mode_i[1] ? rise : fall))
                          : (mode_i[1] ? cur_i[0] : ~cur_i[0]);
        end else if (EDGE_MASK[g]) begin : g_edge
            assign nxt[g] = (pend_q[g] & ~clr_i[g]) | (cur_i[g] & ~prev_i[g]);
        end else begin : g_level
            assign nxt[g] = cur_i[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= nxt;
    end

    assign pend_o = pend_q;

    // R4: a latched edge bit not being cleared survives the next edge
    a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & EDGE_FIXED & ~clr_i) != '0)
        |=> ((pend_q & $past(pend_q & EDGE_FIXED & ~clr_i))
             == $past(pend_q & EDGE_FIXED & ~clr_i)));

endmodule

// File: rtl/sirq_vector.sv
module sirq_vector #(
    parameter int N_IRQ = 8,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] qual_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (qual_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // R9: the chosen index qualifies and nothing below it does
    a_r9_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (qual_i[idx_o] &&
                   ((qual_i & ~({N_IRQ{1'b1}} << idx_o)) == '0)));

endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
#(
    parameter int               N_IRQ     = 8,
    parameter logic [N_IRQ-1:0] EDGE_MASK = N_IRQ'(8'hF0),
    parameter int               ADDR_W    = 8,
    parameter int               DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              nmi_o
);

    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    bus_state_e        state_q, state_d;
    nmi_mode_e         mode_q;
    logic [DATA_W-1:0] base_q, rdata_q, rd_mux, vec_val;
    logic [N_IRQ-1:0]  en_q, mask_q, resp_q;
    logic [N_IRQ-1:0]  sync_cur, sync_prev, pend, clr_w1c, qual;
    logic              acc, wr, vec_hit;
    logic [IDX_W-1:0]  vec_idx;

    sirq_sync #(.N_IRQ(N_IRQ)) u_sync (
        .clk   (clk),
        .raw_i (irq_in),
        .cur_o (sync_cur),
        .prev_o(sync_prev)
    );

    sirq_pending #(.N_IRQ(N_IRQ), .EDGE_MASK(EDGE_MASK)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .cur_i (sync_cur),
        .prev_i(sync_prev),
        .mode_i(mode_q),
        .clr_i (clr_w1c),
        .pend_o(pend)
    );

    assign qual = pend & en_q & ~mask_q & ~resp_q;

    sirq_vector #(.N_IRQ(N_IRQ)) u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .qual_i(qual),
        .hit_o (vec_hit),
        .idx_o (vec_idx)
    );

    assign vec_val = base_q + (DATA_W'(vec_idx) << 2);
    assign irq_o   = |qual;
    assign nmi_o   = pend[0] & en_q[0];

    // bus state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // bus outputs and next state
    always_comb begin
        unique case (state_q)
            BUS_IDLE: begin
                bus_ack = 1'b0;
                acc     = bus_req;
                state_d = bus_req ? BUS_ACK : BUS_IDLE;
            end
            BUS_ACK: begin
                bus_ack = 1'b1;
                acc     = 1'b0;
                state_d = BUS_IDLE;
            end
            default: begin
                bus_ack = 1'b0;
                acc     = 1'b0;
                state_d = BUS_IDLE;
            end
        endcase
    end

    assign wr      = acc & bus_we;
    assign clr_w1c = (wr && bus_addr == ADDR_W'(OFF_PEND)) ? bus_wdata[N_IRQ-1:0] : '0;

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFF_VEC):  rd_mux = vec_val;
            ADDR_W'(OFF_BASE): rd_mux = base_q;
            ADDR_W'(OFF_NMI):  rd_mux = DATA_W'(mode_q);
            ADDR_W'(OFF_PEND): rd_mux = DATA_W'(pend);
            ADDR_W'(OFF_EN):   rd_mux = DATA_W'(en_q);
            ADDR_W'(OFF_MASK): rd_mux = DATA_W'(mask_q);
            ADDR_W'(OFF_RESP): rd_mux = DATA_W'(resp_q);
            default:           rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            mode_q  <= NMI_LOW;
            en_q    <= '0;
            mask_q  <= '0;
            resp_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (acc && !bus_we) rdata_q <= rd_mux;
            if (wr) begin
                case (bus_addr)
                    ADDR_W'(OFF_BASE): base_q <= bus_wdata;
                    ADDR_W'(OFF_NMI):  mode_q <= nmi_mode_e'(bus_wdata[1:0]);
                    ADDR_W'(OFF_EN):   en_q   <= bus_wdata[N_IRQ-1:0];
                    ADDR_W'(OFF_MASK): mask_q <= bus_wdata[N_IRQ-1:0];
                    ADDR_W'(OFF_RESP): resp_q <= bus_wdata[N_IRQ-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;

    // R1: completion is a single-cycle pulse
    a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R8: the request agrees with the lowest-index search
    a_r8_irq_matches_hit: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == vec_hit);

    // R6: the distributor line never rises without enable bit 0
    a_r6_nmi_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> en_q[0]);

endmodule

// File: tb/tb_sirq_ctrl.sv
module tb_sirq_ctrl;
    localparam int N = 8;
    localparam logic [7:0] A_VEC = 8'h00, A_BASE = 8'h04, A_NMI = 8'h0C,
                           A_PEND = 8'h10, A_EN = 8'h40, A_MASK = 8'h50,
                           A_RESP = 8'h60, A_NONE = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = 8'h01;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, irq_o, nmi_o;
    logic [31:0] bus_rdata;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .nmi_o(nmi_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        chk("R1 ack with read", 32'(bus_ack), 32'd1);
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_vec(input logic [31:0] base, input logic [7:0] q);
        logic [31:0] v;
        v = base;
        for (int i = 7; i >= 0; i--) if (q[i]) v = base + 32'(4 * i);
        return v;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 reset state
        chk("R2 irq_o", 32'(irq_o), 0);
        chk("R2 nmi_o", 32'(nmi_o), 0);
        chk("R1 ack idle", 32'(bus_ack), 0);
        bus_rd(A_VEC, d);  chk("R2 vector", d, 0);
        bus_rd(A_BASE, d); chk("R2 base", d, 0);
        bus_rd(A_NMI, d);  chk("R2 mode", d, 0);
        bus_rd(A_PEND, d); chk("R2 pending", d, 0);
        bus_rd(A_EN, d);   chk("R2 enable", d, 0);
        bus_rd(A_MASK, d); chk("R2 mask", d, 0);
        bus_rd(A_RESP, d); chk("R2 response", d, 0);
        @(negedge clk);
        chk("R1 ack one cycle", 32'(bus_ack), 0);

        // R10 readback and R1 unmapped access
        bus_wr(A_EN, 32'hFFFF_FFFF);
        bus_rd(A_EN, d);   chk("R10 enable width", d, 32'h0000_00FF);
        bus_wr(A_BASE, 32'hDEAD_BEEC);
        bus_rd(A_BASE, d); chk("R10 base", d, 32'hDEAD_BEEC);
        bus_wr(A_MASK, 32'h0000_00A5);
        bus_rd(A_MASK, d); chk("R10 mask", d, 32'h0000_00A5);
        bus_wr(A_RESP, 32'h0000_005A);
        bus_rd(A_RESP, d); chk("R10 response", d, 32'h0000_005A);
        bus_wr(A_NONE, 32'h0000_0000);
        bus_rd(A_NONE, d); chk("R1 unmapped read", d, 0);
        bus_rd(A_EN, d);   chk("R1 unmapped write ignored", d, 32'h0000_00FF);

        // R8 / R9 / R3 sweep: mode high level, lines 0..3 level-driven
        bus_wr(A_NMI, 32'd2);
        bus_wr(A_BASE, 32'h0000_1000);
        for (int p = 0; p < 16; p++) begin
            irq_in = 8'(p);
            settle();
            bus_rd(A_PEND, d); chk("R3 level follows", d, 32'(p));
            for (int m = 0; m < 16; m++) begin
                for (int r = 0; r < 16; r++) begin
                    bus_wr(A_MASK, 32'(m));
                    bus_wr(A_RESP, 32'(r));
                    chk("R8 irq_o", 32'(irq_o), 32'((p & ~m & ~r & 15) != 0));
                    chk("R6 nmi_o ignores mask/resp", 32'(nmi_o), 32'(p & 1));
                    bus_rd(A_VEC, d);
                    chk("R9 vector", d, exp_vec(32'h1000, 8'(p & ~m & ~r)));
                end
            end
        end
        bus_wr(A_MASK, 0);
        bus_wr(A_RESP, 0);

        // R3 write-1 to level bits has no effect
        irq_in = 8'h0E;
        settle();
        bus_wr(A_PEND, 32'hFF);
        bus_rd(A_PEND, d); chk("R3 w1c ignored on level", d, 32'h0E);

        // R4 edge lines
        irq_in = 8'h00;
        settle();
        for (int i = 4; i < 8; i++) begin
            irq_in = 8'(1 << i);
            settle();
            bus_rd(A_PEND, d); chk("R4 edge sets", d, 32'(1 << i));
            irq_in = 8'h00;
            settle();
            bus_rd(A_PEND, d); chk("R4 edge held", d, 32'(1 << i));
            chk("R4 irq from edge", 32'(irq_o), 1);
            bus_rd(A_VEC, d);  chk("R9 vector edge", d, 32'h1000 + 32'(4 * i));
            bus_wr(A_PEND, 32'(1 << i));
            bus_rd(A_PEND, d); chk("R4 cleared", d, 0);
        end
        irq_in = 8'h30; settle(); irq_in = 8'h00; settle();
        bus_wr(A_PEND, 32'h10);
        bus_rd(A_PEND, d); chk("R4 selective clear", d, 32'h20);
        bus_wr(A_PEND, 32'h20);

        // R5 NMI modes
        irq_in = 8'h01; bus_wr(A_NMI, 0); settle();
        bus_rd(A_PEND, d); chk("R5 low idle", d, 0);
        irq_in = 8'h00; settle();
        bus_rd(A_PEND, d); chk("R5 low active", d, 1);
        irq_in = 8'h01; settle();
        bus_rd(A_PEND, d); chk("R5 low released", d, 0);
        bus_wr(A_NMI, 2); settle();
        bus_rd(A_PEND, d); chk("R5 high active", d, 1);
        irq_in = 8'h00; settle();
        bus_rd(A_PEND, d); chk("R5 high released", d, 0);
        bus_wr(A_NMI, 3); bus_wr(A_PEND, 1); settle();
        bus_rd(A_PEND, d); chk("R5 rise idle", d, 0);
        irq_in = 8'h01; settle();
        irq_in = 8'h00; settle();
        bus_rd(A_PEND, d); chk("R5 rise held", d, 1);
        bus_wr(A_PEND, 1);
        bus_rd(A_PEND, d); chk("R5 rise cleared", d, 0);
        irq_in = 8'h01; settle();
        bus_wr(A_PEND, 1);
        bus_wr(A_NMI, 1); settle();
        bus_rd(A_PEND, d); chk("R5 fall idle", d, 0);
        bus_rd(A_NMI, d);  chk("R5 mode readback", d, 1);
        irq_in = 8'h00; settle();
        irq_in = 8'h01; settle();
        bus_rd(A_PEND, d); chk("R5 fall held", d, 1);
        bus_wr(A_PEND, 1);
        bus_rd(A_PEND, d); chk("R5 fall cleared", d, 0);

        // R6 / R7 enable effects
        bus_wr(A_NMI, 2);
        irq_in = 8'h03; settle();
        bus_wr(A_EN, 32'hFE);
        chk("R6 nmi_o needs enable 0", 32'(nmi_o), 0);
        bus_wr(A_EN, 32'h01);
        bus_wr(A_MASK, 32'h01);
        bus_wr(A_RESP, 32'h01);
        chk("R6 nmi_o despite mask", 32'(nmi_o), 1);
        chk("R7 irq_o off with en1 clear", 32'(irq_o), 0);
        bus_wr(A_EN, 32'h03);
        chk("R7 nmi_o unchanged", 32'(nmi_o), 1);
        chk("R7 irq_o on with en1 set", 32'(irq_o), 1);

        done = 1;
        summary();
        $finish;
    end
endmodule